// File: doc/BRIEF.md
# Configuration Request Packet Generator

This block turns a single configuration-space read or write request into a three-dword request header, followed by a data dword. It sends them over a 64-bit beat interface that carries start and end markers. A request names a target bus, a device/function number, a byte offset, an access size and, for writes, the write data. The block derives the byte enables and shifts sub-dword write data into its byte lanes. It selects type-0 encoding for the root bus and type-1 encoding for any bus behind it, and packs the header onto beats. Where the data dword lands depends on the quadword alignment of the dword address.

The block also holds the root bus number. A write to the bus-number dword of the root device updates it. Accesses that must not reach the link are turned away locally, with a one-cycle error response and no beats on the link side. Requests enter through a valid/ready handshake. Only one request is in flight at a time, and the beat output honours backpressure.

Top module: `cfg_req_gen`

## Requirements
- R1: The byte-enable field is 0x01 shifted left by offset[1:0] for size code 0 (1 byte), 0x03 shifted left by offset[1:0] for size code 1 (2 bytes), and 0x0F for size codes 2 and 3 (4 bytes). The dword address is the offset with bits [1:0] cleared.
- R2: Write data for size code 0 is masked to 8 bits, and for size code 1 to 16 bits. It is then shifted left by 8×offset[1:0]. Size codes 2 and 3 send the write data unchanged. Reads carry a zero data dword.
- R3: Header dword 0 is {fmt, 24'h000001}. fmt is 0x04 for a read and 0x44 for a write when the target bus equals the root bus. It is 0x05 for a read and 0x45 for a write otherwise.
- R4: Header dword 1 is {root_bus, 8'h00, tag, byte_enables}. tag is 0x1D for reads and 0x10 for writes.
- R5: Header dword 2 is {bus, devfn, dword address zero-extended to 16 bits}.
- R6: Within a beat, the earlier dword occupies bits [31:0]. Beat 0 is {dw1, dw0} with the start marker. A write whose dword address has bit 2 clear sends {0, dw2}, then {0, data} with the end marker, for 3 beats. Every other request sends {data, dw2} with the end marker, for 2 beats.
- R7: An accepted write to dword address 0x18 on the root bus sets root_bus_o to bits [7:0] of the aligned data. This takes effect from the cycle after acceptance and applies to later requests.
- R8: On the root bus, a request is rejected if devfn[7:3] is non-zero, or if devfn is 0 and the dword address is 0x10. On any other bus, a request is rejected while link_up_i is low. The link state is ignored on the root bus.
- R9: A rejected request produces no beats. It pulses rej_valid_o for one cycle, the cycle after acceptance. rej_data_o is 0xFFFFFFFF for a read and 0 for a write.
- R10: req_ready_o is low from acceptance until the beat carrying the end marker has been taken. A beat held by beat_ready_i low keeps its data and markers.
- R11: After reset, root_bus_o is ROOT_RST (default 0), req_ready_o is high, and beat_valid_o and rej_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_devfn_i | input | 8 | Device (bits 7:3) and function (bits 2:0) |
| req_offset_i | input | OFF_W | Register byte offset |
| req_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata_i | input | 32 | Write value, right-justified |
| link_up_i | input | 1 | Link is up |
| beat_valid_o | output | 1 | Beat present |
| beat_ready_i | input | 1 | Beat taken this cycle |
| beat_data_o | output | 64 | Two dwords, earlier one in bits 31:0 |
| beat_sop_o | output | 1 | First beat of a packet |
| beat_eop_o | output | 1 | Last beat of a packet |
| rej_valid_o | output | 1 | Request rejected (one-cycle pulse) |
| rej_data_o | output | 32 | Read value returned for a rejected request |
| root_bus_o | output | 8 | Current root bus number |

## Verification
The assertions assume that request fields are stable only in the cycle they are sampled. They also assume beat_ready_i may be low for any number of cycles, but that the sink eventually takes every beat. The rejection property recomputes the root-bus check from root_bus_o, so it relies on the request arriving in a cycle where req_ready_o is high. The stimulus keeps req_valid_i to a single cycle while the block is idle. It holds beat_ready_i low only in a bounded directed window. It changes the root bus only through the update write, so the table's type and requester fields follow a known sequence.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;
  localparam int DW_W   = 32;
  localparam int BEAT_W = 2 * DW_W;

  localparam logic [7:0] FT_RD_T0 = 8'h04;
  localparam logic [7:0] FT_WR_T0 = 8'h44;
  localparam logic [7:0] FT_RD_T1 = 8'h05;
  localparam logic [7:0] FT_WR_T1 = 8'h45;
  localparam logic [7:0] TAG_RD   = 8'h1D;
  localparam logic [7:0] TAG_WR   = 8'h10;

  localparam int BUSNUM_DWA = 'h18;  // dword holding the bus-number registers
  localparam int HIDDEN_DWA = 'h10;  // first base-address dword of the root device

  typedef struct packed {
    logic [DW_W-1:0] dw0;
    logic [DW_W-1:0] dw1;
    logic [DW_W-1:0] dw2;
    logic [DW_W-1:0] pay;
    logic            three;
  } cfg_pkt_t;
endpackage

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfg_req_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             write_i,
  input  logic [7:0]       bus_i,
  input  logic [7:0]       root_i,
  input  logic [7:0]       devfn_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [1:0]       size_i,
  input  logic [DW_W-1:0]  wdata_i,
  output logic [OFF_W-1:0] dw_addr_o,
  output cfg_pkt_t         pkt_o
);
  localparam int PAD_W = 16 - OFF_W;

  logic [7:0]      be;
  logic [DW_W-1:0] data;
  logic [4:0]      sh;
  logic [7:0]      fmt;

  assign dw_addr_o = {offset_i[OFF_W-1:2], 2'b00};
  assign sh        = {offset_i[1:0], 3'b000};

  always_comb begin
    unique case (size_i)
      2'd0: begin
        be   = 8'h01 << offset_i[1:0];
        data = {24'h0, wdata_i[7:0]} << sh;
      end
      2'd1: begin
        be   = 8'h03 << offset_i[1:0];
        data = {16'h0, wdata_i[15:0]} << sh;
      end
      default: begin
        be   = 8'h0F;
        data = wdata_i;
      end
    endcase
  end

  always_comb begin
    if (bus_i == root_i) fmt = write_i ? FT_WR_T0 : FT_RD_T0;
    else                 fmt = write_i ? FT_WR_T1 : FT_RD_T1;
  end

  assign pkt_o.dw0   = {fmt, 24'h000001};
  assign pkt_o.dw1   = {root_i, 8'h00, (write_i ? TAG_WR : TAG_RD), be};
  assign pkt_o.dw2   = {bus_i, devfn_i, {PAD_W{1'b0}}, dw_addr_o};
  assign pkt_o.pay   = write_i ? data : '0;
  // quadword-aligned writes put the data dword in its own beat
  assign pkt_o.three = write_i && !dw_addr_o[2];
endmodule

// File: rtl/cfg_req_filter.sv
module cfg_req_filter
  import cfg_req_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic [7:0]       bus_i,
  input  logic [7:0]       root_i,
  input  logic [7:0]       devfn_i,
  input  logic [OFF_W-1:0] dw_addr_i,
  input  logic             link_up_i,
  output logic             reject_o
);
  logic on_root;
  logic bad_dev;
  logic hidden;

  assign on_root  = bus_i == root_i;
  assign bad_dev  = devfn_i[7:3] != 5'd0;
  assign hidden   = (devfn_i == 8'd0) && (dw_addr_i == OFF_W'(HIDDEN_DWA));
  assign reject_o = on_root ? (bad_dev || hidden) : !link_up_i;
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
  import cfg_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  cfg_pkt_t          pkt_i,
  input  logic              beat_ready_i,
  output logic              busy_o,
  output logic [BEAT_W-1:0] beat_data_o,
  output logic              beat_sop_o,
  output logic              beat_eop_o
);
  localparam int NB    = 3;
  localparam int IDX_W = $clog2(NB);

  logic [BEAT_W-1:0] beat_q [NB];
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      for (int i = 0; i < NB; i++) beat_q[i] <= '0;
    end else if (load_i) begin
      busy_q    <= 1'b1;
      idx_q     <= '0;
      beat_q[0] <= {pkt_i.dw1, pkt_i.dw0};
      if (pkt_i.three) begin
        beat_q[1] <= {{DW_W{1'b0}}, pkt_i.dw2};
        beat_q[2] <= {{DW_W{1'b0}}, pkt_i.pay};
        last_q    <= IDX_W'(2);
      end else begin
        beat_q[1] <= {pkt_i.pay, pkt_i.dw2};
        beat_q[2] <= '0;
        last_q    <= IDX_W'(1);
      end
    end else if (busy_q && beat_ready_i) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o      = busy_q;
  assign beat_data_o = beat_q[idx_q];
  assign beat_sop_o  = busy_q && (idx_q == '0);
  assign beat_eop_o  = busy_q && (idx_q == last_q);
endmodule

// File: rtl/cfg_req_gen.sv
module cfg_req_gen
  import cfg_req_pkg::*;
#(
  parameter int         OFF_W    = 12,
  parameter logic [7:0] ROOT_RST = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [7:0]        req_bus_i,
  input  logic [7:0]        req_devfn_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic [1:0]        req_size_i,
  input  logic [DW_W-1:0]   req_wdata_i,
  input  logic              link_up_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [BEAT_W-1:0] beat_data_o,
  output logic              beat_sop_o,
  output logic              beat_eop_o,
  output logic              rej_valid_o,
  output logic [DW_W-1:0]   rej_data_o,
  output logic [7:0]        root_bus_o
);
  logic [7:0]       root_q;
  logic             rej_q;
  logic [DW_W-1:0]  rej_data_q;
  logic [OFF_W-1:0] dw_addr;
  logic             reject;
  logic             busy;
  logic             accept;
  logic             load;
  cfg_pkt_t         pkt;

  cfg_hdr_build #(.OFF_W(OFF_W)) u_hdr (
    .write_i   (req_write_i),
    .bus_i     (req_bus_i),
    .root_i    (root_q),
    .devfn_i   (req_devfn_i),
    .offset_i  (req_offset_i),
    .size_i    (req_size_i),
    .wdata_i   (req_wdata_i),
    .dw_addr_o (dw_addr),
    .pkt_o     (pkt)
  );

  cfg_req_filter #(.OFF_W(OFF_W)) u_filt (
    .bus_i     (req_bus_i),
    .root_i    (root_q),
    .devfn_i   (req_devfn_i),
    .dw_addr_i (dw_addr),
    .link_up_i (link_up_i),
    .reject_o  (reject)
  );

  cfg_beat_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .pkt_i        (pkt),
    .beat_ready_i (beat_ready_i),
    .busy_o       (busy),
    .beat_data_o  (beat_data_o),
    .beat_sop_o   (beat_sop_o),
    .beat_eop_o   (beat_eop_o)
  );

  assign accept = req_valid_i && !busy;
  assign load   = accept && !reject;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      root_q     <= ROOT_RST;
      rej_q      <= 1'b0;
      rej_data_q <= '0;
    end else begin
      rej_q      <= accept && reject;
      rej_data_q <= (accept && reject && !req_write_i) ? '1 : '0;
      if (load && req_write_i && (req_bus_i == root_q) &&
          (dw_addr == OFF_W'(BUSNUM_DWA)))
        root_q <= pkt.pay[7:0];
    end
  end

  assign req_ready_o  = !busy;
  assign beat_valid_o = busy;
  assign rej_valid_o  = rej_q;
  assign rej_data_o   = rej_data_q;
  assign root_bus_o   = root_q;
endmodule

// File: rtl/cfg_req_chk.sv
module cfg_req_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_write_i,
  input logic [7:0]  req_bus_i,
  input logic [7:0]  req_devfn_i,
  input logic        beat_valid_o,
  input logic        beat_ready_i,
  input logic [63:0] beat_data_o,
  input logic        beat_sop_o,
  input logic        beat_eop_o,
  input logic        rej_valid_o,
  input logic [31:0] rej_data_o,
  input logic [7:0]  root_bus_o
);
  // R10
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(beat_data_o) && $stable(beat_sop_o) && $stable(beat_eop_o)));

  // R10
  ready_after_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_ready_i && beat_eop_o) |=> (req_ready_o && !beat_valid_o));

  // R6
  sop_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(beat_valid_o) |-> (beat_sop_o && !beat_eop_o));

  // R3
  hdr_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && beat_sop_o) |-> (beat_data_o[23:0] == 24'h000001));

  // R9
  rej_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_valid_o |-> !beat_valid_o);

  // R9
  rej_read_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i && (req_bus_i == root_bus_o) &&
     (req_devfn_i[7:3] != 5'd0)) |=> (rej_valid_o && rej_data_o == 32'hFFFF_FFFF));

  // R7
  root_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(root_bus_o) |-> $past(req_valid_i && req_ready_o && req_write_i));
endmodule

bind cfg_req_gen cfg_req_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .req_bus_i    (req_bus_i),
  .req_devfn_i  (req_devfn_i),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_data_o  (beat_data_o),
  .beat_sop_o   (beat_sop_o),
  .beat_eop_o   (beat_eop_o),
  .rej_valid_o  (rej_valid_o),
  .rej_data_o   (rej_data_o),
  .root_bus_o   (root_bus_o)
);

// File: tb/cfg_req_gen_tb.sv
module cfg_req_gen_tb;
  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        link;
    logic        rej;
    logic [1:0]  nb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0,        1'b1, 1'b0, 2'd2},
    '{1'b0, 8'h01, 8'h08, 12'h003, 2'd0, 32'h0,        1'b1, 1'b0, 2'd2},
    '{1'b1, 8'h02, 8'h11, 12'h006, 2'd1, 32'h1234ABCD, 1'b1, 1'b0, 2'd2},
    '{1'b1, 8'h02, 8'h00, 12'h009, 2'd0, 32'hFFFFFF5A, 1'b1, 1'b0, 2'd3},
    '{1'b0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0,        1'b1, 1'b1, 2'd0},
    '{1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0,        1'b1, 1'b1, 2'd0},
    '{1'b0, 8'h00, 8'h01, 12'h012, 2'd1, 32'h0,        1'b1, 1'b0, 2'd2},
    '{1'b1, 8'h03, 8'h00, 12'h020, 2'd2, 32'h1234,     1'b0, 1'b1, 2'd0},
    '{1'b0, 8'h00, 8'h00, 12'h004, 2'd2, 32'h0,        1'b0, 1'b0, 2'd2},
    '{1'b1, 8'h00, 8'h00, 12'h018, 2'd0, 32'h00000007, 1'b1, 1'b0, 2'd3},
    '{1'b0, 8'h07, 8'h00, 12'h000, 2'd2, 32'h0,        1'b1, 1'b0, 2'd2},
    '{1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0,        1'b0, 1'b1, 2'd0},
    '{1'b1, 8'h09, 8'h10, 12'hFFC, 2'd3, 32'hDEADBEEF, 1'b1, 1'b0, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        link_up = 1'b1;
  logic        beat_valid;
  logic        beat_ready = 1'b1;
  logic [63:0] beat_data;
  logic        beat_sop;
  logic        beat_eop;
  logic        rej_valid;
  logic [31:0] rej_data;
  logic [7:0]  root_bus;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] e_beat [3];
  logic [7:0]  m_root = 8'h00;

  always #2 clk = ~clk;

  cfg_req_gen u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_write_i  (req_write),
    .req_bus_i    (req_bus),
    .req_devfn_i  (req_devfn),
    .req_offset_i (req_offset),
    .req_size_i   (req_size),
    .req_wdata_i  (req_wdata),
    .link_up_i    (link_up),
    .beat_valid_o (beat_valid),
    .beat_ready_i (beat_ready),
    .beat_data_o  (beat_data),
    .beat_sop_o   (beat_sop),
    .beat_eop_o   (beat_eop),
    .rej_valid_o  (rej_valid),
    .rej_data_o   (rej_data),
    .root_bus_o   (root_bus)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected beats from R1..R6, root update per R7
  task automatic model(input vec_t v);
    logic [11:0] dwa;
    logic [7:0]  be;
    logic [31:0] d;
    logic [7:0]  fmt;
    logic [31:0] h0, h1, h2;
    int          sh;
    dwa = v.off & 12'hFFC;
    sh  = 8 * int'(v.off[1:0]);
    if (v.size == 2'd0) begin
      be = 8'h01 << v.off[1:0];
      d  = (v.wdata & 32'hFF) << sh;
    end else if (v.size == 2'd1) begin
      be = 8'h03 << v.off[1:0];
      d  = (v.wdata & 32'hFFFF) << sh;
    end else begin
      be = 8'h0F;
      d  = v.wdata;
    end
    if (!v.wr) d = 32'h0;
    if (v.bus == m_root) fmt = v.wr ? 8'h44 : 8'h04;
    else                 fmt = v.wr ? 8'h45 : 8'h05;
    h0 = {fmt, 24'h000001};
    h1 = {m_root, 8'h00, (v.wr ? 8'h10 : 8'h1D), be};
    h2 = {v.bus, v.devfn, 4'h0, dwa};
    e_beat[0] = {h1, h0};
    if (v.nb == 2'd3) begin
      e_beat[1] = {32'h0, h2};
      e_beat[2] = {32'h0, d};
    end else begin
      e_beat[1] = {d, h2};
      e_beat[2] = '0;
    end
    if (v.wr && !v.rej && v.bus == m_root && dwa == 12'h018) m_root = d[7:0];
  endtask

  task automatic run_vec(input vec_t v, input int k);
    int got;
    model(v);
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready idle", 64'(req_ready), 64'd1);
    req_write = v.wr; req_bus = v.bus; req_devfn = v.devfn; req_offset = v.off;
    req_size = v.size; req_wdata = v.wdata; link_up = v.link; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.rej) begin
      check(rej_valid == 1'b1, "R8 reject flag", 64'(rej_valid), 64'd1);
      check(rej_data == (v.wr ? 32'h0 : 32'hFFFFFFFF), "R9 reject data",
            64'(rej_data), 64'(v.wr ? 32'h0 : 32'hFFFFFFFF));
      check(beat_valid == 1'b0, "R9 no beats", 64'(beat_valid), 64'd0);
      @(negedge clk);
      check(rej_valid == 1'b0, "R9 single pulse", 64'(rej_valid), 64'd0);
      check(beat_valid == 1'b0, "R9 still no beats", 64'(beat_valid), 64'd0);
    end else begin
      check(rej_valid == 1'b0, "R8 accepted", 64'(rej_valid), 64'd0);
      got = 0;
      for (int b = 0; b < 4; b++) begin
        if (!beat_valid) break;
        got = b + 1;
        check(req_ready == 1'b0, "R10 ready low in packet", 64'(req_ready), 64'd0);
        if (b < 3) begin
          check(beat_data == e_beat[b], "R1 R2 R3 R4 R5 beat data", beat_data, e_beat[b]);
          check(beat_sop == (b == 0), "R6 sop", 64'(beat_sop), 64'(b == 0));
          check(beat_eop == (b == int'(v.nb) - 1), "R6 eop", 64'(beat_eop),
                64'(b == int'(v.nb) - 1));
        end
        @(negedge clk);
        if (beat_eop === 1'b0 && !beat_valid) break;
      end
      check(got == int'(v.nb), "R6 beat count", 64'(got), 64'(v.nb));
    end
    check(root_bus == m_root, "R7 root bus", 64'(root_bus), 64'(m_root));
    if (k < 0) $display("unused");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(req_ready == 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
    check(beat_valid == 1'b0, "R11 no beat in reset", 64'(beat_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(root_bus == 8'h00, "R11 root reset", 64'(root_bus), 64'h0);
    check(rej_valid == 1'b0, "R11 no reject", 64'(rej_valid), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10 backpressure: beat_ready low holds beat 0 for three cycles
    @(negedge clk);
    beat_ready = 1'b0;
    req_write = 1'b0; req_bus = 8'h05; req_devfn = 8'h20; req_offset = 12'h044;
    req_size = 2'd2; link_up = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check(beat_valid && beat_sop && !beat_eop, "R10 held beat markers",
            64'({beat_valid, beat_sop, beat_eop}), 64'b110);
      check(beat_data == {32'h07001D0F, 32'h05000001}, "R10 held beat data",
            beat_data, {32'h07001D0F, 32'h05000001});
      check(req_ready == 1'b0, "R10 no accept while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    beat_ready = 1'b1;
    @(negedge clk);
    check(beat_eop && beat_data == {32'h0, 32'h05200044}, "R10 second beat after release",
          beat_data, {32'h0, 32'h05200044});
    @(negedge clk);
    check(req_ready && !beat_valid, "R10 idle after eop", 64'({req_ready, beat_valid}), 64'b10);

    // R11 reset restores root bus
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(root_bus == 8'h00, "R11 root after second reset", 64'(root_bus), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule